// File: doc/BRIEF.md
# SMRAM and TSEG Access Controller

This block holds the two 8-bit configuration registers that decide where system-management memory can be seen. The first register controls the legacy management window at 0xA0000 to 0xBFFFF. Its bits are an open bit, a sticky lock bit and a global enable. The second register holds a bit that moves the window to its high alias, a size code and an enable for a protected segment that sits just below the top of memory below 4 GiB.

A configuration agent writes either register through a one-byte write port. Internal write masks limit which bits a write can change. Setting the lock bit clears the open bit and reduces both masks until the next reset.

From the register state, the block drives the window enables for the normal view and for the management view. It also drives the base and size of the protected segment. A combinational classifier takes a requested address and a management-mode flag and reports where the access goes: to RAM, to the bus, to RAM through the high alias, or to a blackhole that reads all ones and drops writes. For an alias hit it also gives the translated RAM address.

Top module: `smm_window_ctrl`

## Requirements
- R1: After reset the control register reads 0x02 and the extended register reads 0x00. The segment size is 0. A normal access to 0xA0000 classifies as bus. The class codes are 0 = RAM, 1 = bus, 2 = high alias, 3 = blackhole.
- R2: `cfg_sel` = 0 writes the control register and `cfg_sel` = 1 writes the extended register. Before lock, only bits 6, 4 and 3 of the control register and bits 7, 2, 1 and 0 of the extended register take the written value. All other bits keep their reset values.
- R3: In the control register, bit 6 is open, bit 4 is lock and bit 3 is the global enable. A write that sets lock also clears open in that same write. After that, no write changes either register until reset.
- R4: In the normal view with open set, the legacy window goes to RAM only while the high bit (extended bit 7) is clear. The high alias at 0xFEDA0000 to 0xFEDBFFFF is shown only while the high bit is set. With open clear, the legacy window goes to the bus and the alias is hidden.
- R5: In the management view with the global enable set, the legacy window goes to RAM if the high bit is clear, and the alias is shown if the high bit is set. With the global enable clear, management accesses are classified as in the normal view.
- R6: When extended bit 0 is set, the size code in bits 2:1 selects the segment size: 0 gives 1 MiB, 1 gives 2 MiB, 2 gives 8 MiB and 3 gives `ext_mib` MiB. When extended bit 0 is clear, the size is 0.
- R7: The segment base equals `low_top` minus the size. Inside the range from base up to but not including `low_top`, a normal access classifies as blackhole and a management access classifies as RAM.
- R8: An access that hits a shown alias classifies as high alias. Its RAM address is the address minus 0xFEDA0000 plus 0xA0000.
- R9: Outside the windows and the segment, an address below `low_top` classifies as RAM and any other address classifies as bus. The RAM address equals the request address.
- R10: A reset after lock restores the default register values and the full write masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = control register, 1 = extended register |
| cfg_wdata | input | 8 | Write data |
| low_top | input | ADDR_W | Size of memory below 4 GiB |
| ext_mib | input | EXT_W | Segment size in MiB for size code 3 |
| smram_rd | output | 8 | Control register value |
| ext_rd | output | 8 | Extended register value |
| nrm_low_ram | output | 1 | Normal view sees RAM in the legacy window |
| nrm_high_alias | output | 1 | Normal view sees the high alias |
| mgmt_low_en | output | 1 | Management view sees the legacy window |
| mgmt_high_en | output | 1 | Management view sees the high alias |
| seg_base | output | ADDR_W | Segment base address |
| seg_size | output | ADDR_W | Segment size in bytes |
| req_addr | input | ADDR_W | Address to classify |
| req_mgmt | input | 1 | Request is a management-mode access |
| req_cls | output | 2 | Access class |
| req_ram_addr | output | ADDR_W | RAM address for the request |

## Verification
The hardest state to reach is the locked one. The bench has to show that open is cleared in the same write that sets lock. It also has to show that every later write to either register is dropped. The bench first opens the window, then sets lock together with other bits, and then writes full patterns to both registers. It reads both registers back each time. Only a reset then brings the masks back, and the bench confirms this by writing the open bit again after reset.

// File: rtl/smm_pkg.sv
package smm_pkg;

    localparam int unsigned OPEN_BIT = 6;
    localparam int unsigned LOCK_BIT = 4;
    localparam int unsigned GLOB_BIT = 3;

    localparam int unsigned HIGH_BIT = 7;
    localparam int unsigned SZ_MSB   = 2;
    localparam int unsigned SZ_LSB   = 1;
    localparam int unsigned SEG_BIT  = 0;

    localparam logic [7:0] SMRAM_RST    = 8'h02;
    localparam logic [7:0] SMRAM_WM     = 8'h58;
    localparam logic [7:0] SMRAM_WM_LCK = 8'h00;
    localparam logic [7:0] EXT_RST      = 8'h00;
    localparam logic [7:0] EXT_WM       = 8'h87;
    localparam logic [7:0] EXT_WM_LCK   = 8'h00;

    localparam logic [31:0] LEG_LO   = 32'h000A_0000;
    localparam logic [31:0] LEG_SPAN = 32'h0002_0000;
    localparam logic [31:0] HI_BASE  = 32'hFEDA_0000;

    localparam int unsigned MIB_SHIFT = 20;

    typedef enum logic [1:0] {
        CLS_RAM   = 2'd0,
        CLS_BUS   = 2'd1,
        CLS_ALIAS = 2'd2,
        CLS_HOLE  = 2'd3
    } acc_cls_e;

    typedef struct packed {
        logic [7:0] smram;
        logic [7:0] ext;
        logic [7:0] smram_wm;
        logic [7:0] ext_wm;
    } smm_regs_t;

endpackage

// File: rtl/smm_reg_bank.sv
module smm_reg_bank
    import smm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic       cfg_sel,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] smram_val,
    output logic [7:0] ext_val
);

    smm_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (cfg_wr) begin
            if (cfg_sel == 1'b0) begin
                regs_d.smram = (regs_q.smram & ~regs_q.smram_wm)
                             | (cfg_wdata & regs_q.smram_wm);
            end else begin
                regs_d.ext = (regs_q.ext & ~regs_q.ext_wm)
                           | (cfg_wdata & regs_q.ext_wm);
            end
        end
        if (regs_d.smram[LOCK_BIT]) begin
            regs_d.smram[OPEN_BIT] = 1'b0;
            regs_d.smram_wm        = SMRAM_WM_LCK;
            regs_d.ext_wm          = EXT_WM_LCK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.smram    <= SMRAM_RST;
            regs_q.ext      <= EXT_RST;
            regs_q.smram_wm <= SMRAM_WM;
            regs_q.ext_wm   <= EXT_WM;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign smram_val = regs_q.smram;
    assign ext_val   = regs_q.ext;

endmodule

// File: rtl/smm_view_decode.sv
module smm_view_decode
    import smm_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned EXT_W  = 12
) (
    input  logic              open_bit,
    input  logic              glob_bit,
    input  logic              high_bit,
    input  logic              seg_en,
    input  logic [1:0]        sz_code,
    input  logic [ADDR_W-1:0] low_top,
    input  logic [EXT_W-1:0]  ext_mib,
    output logic              nrm_low_ram,
    output logic              nrm_high_alias,
    output logic              mgmt_low_en,
    output logic              mgmt_high_en,
    output logic [ADDR_W-1:0] seg_base,
    output logic [ADDR_W-1:0] seg_size
);

    localparam logic [ADDR_W-1:0] ONE_MIB = ADDR_W'(1) << MIB_SHIFT;

    logic [ADDR_W-1:0] size_sel;

    always_comb begin
        case (sz_code)
            2'd0:    size_sel = ONE_MIB;
            2'd1:    size_sel = ONE_MIB << 1;
            2'd2:    size_sel = ONE_MIB << 3;
            default: size_sel = ADDR_W'(ext_mib) << MIB_SHIFT;
        endcase
    end

    assign seg_size       = seg_en ? size_sel : '0;
    assign seg_base       = low_top - seg_size;
    assign nrm_low_ram    = open_bit & ~high_bit;
    assign nrm_high_alias = open_bit &  high_bit;
    assign mgmt_low_en    = glob_bit & ~high_bit;
    assign mgmt_high_en   = glob_bit &  high_bit;

endmodule

// File: rtl/smm_addr_class.sv
module smm_addr_class
    import smm_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              nrm_low_ram,
    input  logic              nrm_high_alias,
    input  logic              mgmt_low_en,
    input  logic              mgmt_high_en,
    input  logic [ADDR_W-1:0] seg_base,
    input  logic [ADDR_W-1:0] seg_size,
    input  logic [ADDR_W-1:0] low_top,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_mgmt,
    output logic [1:0]        req_cls,
    output logic [ADDR_W-1:0] req_ram_addr
);

    localparam logic [ADDR_W-1:0] LO_A  = ADDR_W'(LEG_LO);
    localparam logic [ADDR_W-1:0] LO_Z  = ADDR_W'(LEG_LO + LEG_SPAN - 32'd1);
    localparam logic [ADDR_W-1:0] HI_A  = ADDR_W'(HI_BASE);
    localparam logic [ADDR_W-1:0] HI_Z  = ADDR_W'(HI_BASE + LEG_SPAN - 32'd1);

    logic     in_seg, in_leg, in_hi;
    acc_cls_e base_cls, cls;

    assign in_seg = (seg_size != '0) && (req_addr >= seg_base) && (req_addr < low_top);
    assign in_leg = (req_addr >= LO_A) && (req_addr <= LO_Z);
    assign in_hi  = (req_addr >= HI_A) && (req_addr <= HI_Z);

    always_comb begin
        if (in_leg)
            base_cls = nrm_low_ram ? CLS_RAM : CLS_BUS;
        else if (in_hi)
            base_cls = nrm_high_alias ? CLS_ALIAS : CLS_BUS;
        else if (req_addr < low_top)
            base_cls = CLS_RAM;
        else
            base_cls = CLS_BUS;

        if (in_seg)
            cls = req_mgmt ? CLS_RAM : CLS_HOLE;
        else if (req_mgmt && in_leg && mgmt_low_en)
            cls = CLS_RAM;
        else if (req_mgmt && in_hi && mgmt_high_en)
            cls = CLS_ALIAS;
        else
            cls = base_cls;
    end

    assign req_cls      = cls;
    assign req_ram_addr = (cls == CLS_ALIAS) ? (req_addr - HI_A + LO_A) : req_addr;

endmodule

// File: rtl/smm_window_ctrl.sv
module smm_window_ctrl
    import smm_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned EXT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [7:0]        cfg_wdata,
    input  logic [ADDR_W-1:0] low_top,
    input  logic [EXT_W-1:0]  ext_mib,
    output logic [7:0]        smram_rd,
    output logic [7:0]        ext_rd,
    output logic              nrm_low_ram,
    output logic              nrm_high_alias,
    output logic              mgmt_low_en,
    output logic              mgmt_high_en,
    output logic [ADDR_W-1:0] seg_base,
    output logic [ADDR_W-1:0] seg_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_mgmt,
    output logic [1:0]        req_cls,
    output logic [ADDR_W-1:0] req_ram_addr
);

    smm_reg_bank u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .smram_val (smram_rd),
        .ext_val   (ext_rd)
    );

    smm_view_decode #(.ADDR_W(ADDR_W), .EXT_W(EXT_W)) u_view (
        .open_bit       (smram_rd[OPEN_BIT]),
        .glob_bit       (smram_rd[GLOB_BIT]),
        .high_bit       (ext_rd[HIGH_BIT]),
        .seg_en         (ext_rd[SEG_BIT]),
        .sz_code        (ext_rd[SZ_MSB:SZ_LSB]),
        .low_top        (low_top),
        .ext_mib        (ext_mib),
        .nrm_low_ram    (nrm_low_ram),
        .nrm_high_alias (nrm_high_alias),
        .mgmt_low_en    (mgmt_low_en),
        .mgmt_high_en   (mgmt_high_en),
        .seg_base       (seg_base),
        .seg_size       (seg_size)
    );

    smm_addr_class #(.ADDR_W(ADDR_W)) u_cls (
        .nrm_low_ram    (nrm_low_ram),
        .nrm_high_alias (nrm_high_alias),
        .mgmt_low_en    (mgmt_low_en),
        .mgmt_high_en   (mgmt_high_en),
        .seg_base       (seg_base),
        .seg_size       (seg_size),
        .low_top        (low_top),
        .req_addr       (req_addr),
        .req_mgmt       (req_mgmt),
        .req_cls        (req_cls),
        .req_ram_addr   (req_ram_addr)
    );

endmodule

// File: rtl/smm_window_chk.sv
module smm_window_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        smram_rd,
    input logic [7:0]        ext_rd,
    input logic              mgmt_low_en,
    input logic              mgmt_high_en,
    input logic [ADDR_W-1:0] low_top,
    input logic [ADDR_W-1:0] seg_base,
    input logic [ADDR_W-1:0] seg_size,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_mgmt,
    input logic [1:0]        req_cls
);

    // R2: fixed bits of the control register never move
    a_r2_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        smram_rd[2:0] == 3'b010);

    // R3: a locked control register never shows open
    a_r3_lock_clears_open: assert property (@(posedge clk) disable iff (!rst_n)
        smram_rd[4] |-> !smram_rd[6]);

    // R3: once locked, both registers hold
    a_r3_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        smram_rd[4] |=> (smram_rd[4] && $stable(ext_rd)));

    // R5: management windows are off without the global enable
    a_r5_glob_off: assert property (@(posedge clk) disable iff (!rst_n)
        !smram_rd[3] |-> (!mgmt_low_en && !mgmt_high_en));

    // R6: a nonzero segment needs its enable bit
    a_r6_size_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_size != '0) |-> ext_rd[0]);

    // R7: base and size end at the low-memory top
    a_r7_base_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_base + seg_size) == low_top);

    // R7: normal accesses inside the segment hit the blackhole
    a_r7_hole: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_mgmt && seg_size != '0 && req_addr >= seg_base && req_addr < low_top)
        |-> req_cls == 2'd3);

endmodule

bind smm_window_ctrl smm_window_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .smram_rd     (smram_rd),
    .ext_rd       (ext_rd),
    .mgmt_low_en  (mgmt_low_en),
    .mgmt_high_en (mgmt_high_en),
    .low_top      (low_top),
    .seg_base     (seg_base),
    .seg_size     (seg_size),
    .req_addr     (req_addr),
    .req_mgmt     (req_mgmt),
    .req_cls      (req_cls)
);

// File: tb/sim_smm_window_ctrl.sv
`timescale 1ns/1ps
module sim_smm_window_ctrl;

    localparam int ADDR_W = 32;
    localparam int EXT_W  = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr = 1'b0;
    logic              cfg_sel = 1'b0;
    logic [7:0]        cfg_wdata = '0;
    logic [ADDR_W-1:0] low_top = 32'h8000_0000;
    logic [EXT_W-1:0]  ext_mib = 12'd16;
    logic [7:0]        smram_rd, ext_rd;
    logic              nrm_low_ram, nrm_high_alias, mgmt_low_en, mgmt_high_en;
    logic [ADDR_W-1:0] seg_base, seg_size;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_mgmt = 1'b0;
    logic [1:0]        req_cls;
    logic [ADDR_W-1:0] req_ram_addr;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    smm_window_ctrl #(.ADDR_W(ADDR_W), .EXT_W(EXT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .low_top(low_top), .ext_mib(ext_mib),
        .smram_rd(smram_rd), .ext_rd(ext_rd), .nrm_low_ram(nrm_low_ram),
        .nrm_high_alias(nrm_high_alias), .mgmt_low_en(mgmt_low_en),
        .mgmt_high_en(mgmt_high_en), .seg_base(seg_base), .seg_size(seg_size),
        .req_addr(req_addr), .req_mgmt(req_mgmt), .req_cls(req_cls),
        .req_ram_addr(req_ram_addr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cls_chk(input string req, input logic [31:0] a, input logic m,
                           input logic [1:0] exp);
        req_addr = a; req_mgmt = m;
        #1;
        chk(req, {30'd0, req_cls}, {30'd0, exp});
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset;
        chk("R1 smram", {24'd0, smram_rd}, 32'h02);
        chk("R1 ext", {24'd0, ext_rd}, 32'h00);
        chk("R1 size", seg_size, 32'h0);
        cls_chk("R1 legacy bus", 32'h000A_0000, 1'b0, 2'd1);
        cls_chk("R9 low ram", 32'h0000_1000, 1'b0, 2'd0);
        cls_chk("R9 above top", 32'h9000_0000, 1'b0, 2'd1);
        chk("R9 ram addr", req_ram_addr, 32'h9000_0000);
    endtask

    task automatic t_mask;
        wr(1'b0, 8'hEF);
        chk("R2 smram mask", {24'd0, smram_rd}, 32'h4A);
        wr(1'b1, 8'hFF);
        chk("R2 ext mask", {24'd0, ext_rd}, 32'h87);
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h00);
        chk("R2 smram clear", {24'd0, smram_rd}, 32'h02);
        chk("R2 ext clear", {24'd0, ext_rd}, 32'h00);
    endtask

    task automatic t_normal;
        wr(1'b0, 8'h40);
        chk("R4 low ram en", {31'd0, nrm_low_ram}, 32'd1);
        cls_chk("R4 open low", 32'h000B_FFFF, 1'b0, 2'd0);
        cls_chk("R4 open hi hidden", 32'hFEDA_0000, 1'b0, 2'd1);
        wr(1'b1, 8'h80);
        cls_chk("R4 hen low bus", 32'h000A_0000, 1'b0, 2'd1);
        cls_chk("R8 alias", 32'hFEDA_1234, 1'b0, 2'd2);
        chk("R8 alias addr", req_ram_addr, 32'h000A_1234);
        cls_chk("R8 alias end", 32'hFEDB_FFFF, 1'b0, 2'd2);
        cls_chk("R8 past alias", 32'hFEDC_0000, 1'b0, 2'd1);
        wr(1'b0, 8'h00);
        cls_chk("R4 closed hi", 32'hFEDA_1234, 1'b0, 2'd1);
        wr(1'b1, 8'h00);
    endtask

    task automatic t_mgmt;
        wr(1'b0, 8'h08);
        cls_chk("R5 mgmt low", 32'h000A_0000, 1'b1, 2'd0);
        cls_chk("R5 normal low", 32'h000A_0000, 1'b0, 2'd1);
        wr(1'b1, 8'h80);
        cls_chk("R5 mgmt hi", 32'hFEDA_0000, 1'b1, 2'd2);
        cls_chk("R5 mgmt low off", 32'h000A_0000, 1'b1, 2'd1);
        wr(1'b0, 8'h00);
        cls_chk("R5 glob off hi", 32'hFEDA_0000, 1'b1, 2'd1);
        wr(1'b1, 8'h00);
        cls_chk("R5 glob off low", 32'h000A_0000, 1'b1, 2'd1);
    endtask

    task automatic t_seg;
        wr(1'b1, 8'h01);
        chk("R6 1MiB", seg_size, 32'h0010_0000);
        chk("R7 base", seg_base, 32'h7FF0_0000);
        cls_chk("R7 hole lo", 32'h7FF0_0000, 1'b0, 2'd3);
        cls_chk("R7 hole hi", 32'h7FFF_FFFF, 1'b0, 2'd3);
        cls_chk("R7 below", 32'h7FEF_FFFF, 1'b0, 2'd0);
        cls_chk("R7 mgmt ram", 32'h7FF0_0000, 1'b1, 2'd0);
        cls_chk("R7 at top", 32'h8000_0000, 1'b0, 2'd1);
        wr(1'b1, 8'h03);
        chk("R6 2MiB", seg_size, 32'h0020_0000);
        wr(1'b1, 8'h05);
        chk("R6 8MiB", seg_size, 32'h0080_0000);
        wr(1'b1, 8'h07);
        chk("R6 ext", seg_size, 32'h0100_0000);
        chk("R7 ext base", seg_base, 32'h7F00_0000);
        wr(1'b1, 8'h06);
        chk("R6 disabled", seg_size, 32'h0);
        cls_chk("R6 no hole", 32'h7FFF_0000, 1'b0, 2'd0);
        wr(1'b1, 8'h00);
    endtask

    task automatic t_lock;
        wr(1'b0, 8'h40);
        wr(1'b0, 8'h50);
        chk("R3 lock open clr", {24'd0, smram_rd}, 32'h12);
        chk("R3 low hidden", {31'd0, nrm_low_ram}, 32'd0);
        wr(1'b0, 8'h48);
        chk("R3 smram held", {24'd0, smram_rd}, 32'h12);
        wr(1'b1, 8'h87);
        chk("R3 ext held", {24'd0, ext_rd}, 32'h00);
    endtask

    task automatic t_relock;
        do_reset();
        chk("R10 smram", {24'd0, smram_rd}, 32'h02);
        wr(1'b0, 8'h40);
        chk("R10 writable", {24'd0, smram_rd}, 32'h42);
        wr(1'b1, 8'h01);
        chk("R10 ext writable", {24'd0, ext_rd}, 32'h01);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        t_reset();
        t_mask();
        t_normal();
        t_mgmt();
        t_seg();
        t_lock();
        t_relock();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule